// File: doc/BRIEF.md
# Parallel Programming-Mode Entry Sequencer

This block sits on the host side of a high-voltage parallel programming link. It steps a target device into programming mode in a fixed, timed order. First it holds the target's reset line low and emits a burst of clock pulses on the target clock pin. Next it drives the four program-enable pins to all zeros and waits a setup time. Then it raises the enable of an external high-voltage switch, which lifts the reset pin to about 12 V. Finally it waits a settle time before it reports that commands may follow. Every delay is given in nanoseconds and turned into whole system-clock cycles, rounded up, from a clock-frequency parameter.

A one-cycle `start_i` pulse begins the sequence. `busy_o` is high while the sequence runs. `ready_o` is a level that stays high once reached. `abort_i` drops the high voltage at once and returns everything to the idle state. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset the outputs are idle: `tgt_rst_low_o`=1, `hv_en_o`=0, `tgt_clk_o`=0, `pen_o`=`PEN_IDLE` (default 4'hF), `busy_o`=0, `ready_o`=0.
- R2: A start pulse in idle sets `busy_o` in the next cycle. It then produces exactly `PULSES` (default 6) rising edges on `tgt_clk_o`, each level lasting `HALF_CYC` cycles. During the burst `pen_o` stays at `PEN_IDLE` and `hv_en_o` stays 0.
- R3: After the burst, with `tgt_clk_o` low, `pen_o` goes to 4'b0000. `hv_en_o` rises exactly ceil(`SETUP_NS`·`CLK_HZ`/1e9) cycles later (5 by default).
- R4: `tgt_rst_low_o` is always the complement of `hv_en_o`. Whenever `hv_en_o` is 1, `pen_o` is 4'b0000.
- R5: While `hv_en_o` stays high, `pen_o` does not change. This covers the guard window after the high voltage is applied.
- R6: `ready_o` rises exactly ceil(`SETTLE_NS`·`CLK_HZ`/1e9) cycles after `hv_en_o` rises (2500 by default), and `busy_o` falls in the same cycle.
- R7: `ready_o` stays high until an abort or a new start.
- R8: `abort_i` in any state returns all outputs to the R1 idle values in the next cycle. Abort wins over a start in the same cycle, and also over the settle delay ending in the same cycle.
- R9: A start pulse while `busy_o` is high is ignored. The sequence keeps the same burst and the same total length.
- R10: A start pulse while `ready_o` is high restarts the sequence. In the next cycle `ready_o`=0, `busy_o`=1 and `hv_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin entry |
| abort_i | input | 1 | Abandon entry and return to idle |
| tgt_rst_low_o | output | 1 | 1 = pull target reset to ground |
| tgt_clk_o | output | 1 | Clock pulses to the target |
| pen_o | output | PEN_W | Program-enable pin levels |
| hv_en_o | output | 1 | Enable for the external high-voltage switch |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Programming mode reached (level) |

## Verification
Two functions can land in the same cycle. The first case is an abort arriving on the very last cycle of the settle delay, which is the cycle in which completion would otherwise set ready. The bench provokes it by counting exactly one cycle fewer than the settle count after `hv_en_o` is first seen, then pulsing abort. It passes only if ready never appears and the high voltage drops. The second case is an abort and a start in the same cycle while ready is held. The result must be idle, not a restart.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CLOCK   = 3'd1,
    ST_PSETUP  = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_READY   = 3'd4
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pe_cyc_timer.sv
module pe_cyc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= val_i;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

  // R6: a loaded count runs down one step per cycle
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pe_clk_pulser.sv
module pe_clk_pulser #(
  parameter int HALF_CYC = 2,
  parameter int PULSES   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic clk_o,
  output logic done_o
);
  localparam int EDGES = 2 * PULSES;
  localparam int HW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int EW    = $clog2(EDGES + 1);

  logic [HW-1:0] half_cnt;
  logic [EW-1:0] edge_cnt;
  logic          run;

  assign done_o = (edge_cnt == EW'(EDGES));
  assign run    = en_i && !done_o;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      half_cnt <= '0;
      edge_cnt <= '0;
      clk_o    <= 1'b0;
    end else if (run) begin
      if (half_cnt == HW'(HALF_CYC - 1)) begin
        half_cnt <= '0;
        clk_o    <= ~clk_o;
        edge_cnt <= edge_cnt + 1'b1;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !clk_o);
  // R2
  edge_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EW'(EDGES));
  // R3
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !clk_o);
endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
  import prog_entry_pkg::*;
#(
  parameter int          CLK_HZ    = 50_000_000,
  parameter int          SETUP_NS  = 100,
  parameter int          SETTLE_NS = 50_000,
  parameter int          HALF_CYC  = 2,
  parameter int          PULSES    = 6,
  parameter int          PEN_W     = 4,
  parameter logic [PEN_W-1:0] PEN_IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             tgt_rst_low_o,
  output logic             tgt_clk_o,
  output logic [PEN_W-1:0] pen_o,
  output logic             hv_en_o,
  output logic             busy_o,
  output logic             ready_o
);
  localparam int SETUP_CYC  = ns_to_cyc(longint'(SETUP_NS),  longint'(CLK_HZ));
  localparam int SETTLE_CYC = ns_to_cyc(longint'(SETTLE_NS), longint'(CLK_HZ));
  localparam int TMAX       = (SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC;
  localparam int TW         = $clog2(TMAX + 1);

  seq_state_t st, nx;
  logic       t_zero, t_load, burst_done, pulser_en;
  logic [TW-1:0] t_val;

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE:   if (start_i)    nx = ST_CLOCK;
      ST_CLOCK:  if (burst_done) nx = ST_PSETUP;
      ST_PSETUP: if (t_zero)     nx = ST_SETTLE;
      ST_SETTLE: if (t_zero)     nx = ST_READY;
      ST_READY:  if (start_i)    nx = ST_CLOCK;
      default:                   nx = ST_IDLE;
    endcase
    if (abort_i) nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end

  assign t_load = (st != nx) && (nx == ST_PSETUP || nx == ST_SETTLE);
  assign t_val  = (nx == ST_PSETUP) ? TW'(SETUP_CYC - 1) : TW'(SETTLE_CYC - 1);

  pe_cyc_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  assign pulser_en = (st == ST_CLOCK) && !abort_i;

  pe_clk_pulser #(.HALF_CYC(HALF_CYC), .PULSES(PULSES)) u_pulser (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (pulser_en),
    .clk_o  (tgt_clk_o),
    .done_o (burst_done)
  );

  assign hv_en_o       = (st == ST_SETTLE) || (st == ST_READY);
  assign tgt_rst_low_o = !hv_en_o;
  assign pen_o         = (st == ST_IDLE || st == ST_CLOCK) ? PEN_IDLE : '0;
  assign busy_o        = (st == ST_CLOCK) || (st == ST_PSETUP) || (st == ST_SETTLE);
  assign ready_o       = (st == ST_READY);

  // R4
  hv_pen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en_o |-> (pen_o == '0));
  // R5
  pen_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en_o && $past(hv_en_o)) |-> $stable(pen_o));
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!hv_en_o && !busy_o && !ready_o && !tgt_clk_o));
  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i && !abort_i) |=> ready_o);
  // R6
  ready_after_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(hv_en_o) && !busy_o));
  // R9
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !abort_i) |=> (busy_o || ready_o));
endmodule

// File: tb/sim_prog_entry_seq.sv
module sim_prog_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam longint HZ     = 100_000_000 / 2;
  localparam int PULSES     = 6;
  localparam int HALF       = 2;
  localparam int P_CYC      = int'((100 * HZ + 999_999_999) / 1_000_000_000);
  localparam int S_CYC      = int'((50_000 * HZ + 999_999_999) / 1_000_000_000);

  logic clk = 0, rst_n = 0, start = 0, abort = 0;
  logic tgt_rst_low, tgt_clk, hv_en, busy, ready;
  logic [3:0] pen;

  int checks = 0, errors = 0;
  int cyc = 0, rises = 0, pen_fall = -1, hv_rise = -1, rdy_rise = -1;
  int rises_at_fall = -1, start_cyc = 0, baseline = 0;
  logic clk_at_fall = 1'b1, busy_at_rdy = 1'b1;
  int r4_bad = 0, r5_bad = 0;
  logic p_tclk = 0, p_hv = 0, p_rdy = 0;
  logic [3:0] p_pen = 4'hF;

  prog_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
    .tgt_rst_low_o(tgt_rst_low), .tgt_clk_o(tgt_clk), .pen_o(pen),
    .hv_en_o(hv_en), .busy_o(busy), .ready_o(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tgt_clk && !p_tclk) rises = rises + 1;
    if (p_pen != 4'h0 && pen == 4'h0) begin
      pen_fall = cyc; clk_at_fall = tgt_clk; rises_at_fall = rises;
    end
    if (hv_en && !p_hv) hv_rise = cyc;
    if (ready && !p_rdy) begin rdy_rise = cyc; busy_at_rdy = busy; end
    if (tgt_rst_low == hv_en) r4_bad = r4_bad + 1;
    if (hv_en && !tgt_rst_low && pen != 4'h0) r4_bad = r4_bad + 1;
    if (p_hv && hv_en && pen != p_pen) r5_bad = r5_bad + 1;
    p_tclk = tgt_clk; p_hv = hv_en; p_rdy = ready; p_pen = pen;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear_mon();
    rises = 0; pen_fall = -1; hv_rise = -1; rdy_rise = -1;
    rises_at_fall = -1; clk_at_fall = 1'b1; busy_at_rdy = 1'b1;
    r4_bad = 0; r5_bad = 0;
  endtask

  task automatic pulse_start();
    start = 1; step(); start = 0;
  endtask

  task automatic wait_ready(input string tag);
    for (int i = 0; i < 6000 && !ready; i++) step();
    chk(ready, tag, ready, 1);
  endtask

  task automatic expect_idle(input string tag);
    chk(!busy && !ready && !hv_en && tgt_rst_low && !tgt_clk && pen == 4'hF,
        tag, {busy, ready, hv_en, tgt_rst_low, tgt_clk}, 5'b00010);
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    expect_idle("R1 reset outputs");
    rst_n = 1; step();
    expect_idle("R1 after release");
  endtask

  task automatic t_full_entry();
    clear_mon(); start_cyc = cyc;
    pulse_start();
    chk(busy, "R2 busy after start", busy, 1);
    wait_ready("R6 ready reached");
    chk(rises_at_fall == PULSES, "R2 pulse count", rises_at_fall, PULSES);
    chk(clk_at_fall == 1'b0, "R3 clock low at pen change", clk_at_fall, 0);
    chk(hv_rise - pen_fall == P_CYC, "R3 setup delay", hv_rise - pen_fall, P_CYC);
    chk(rdy_rise - hv_rise == S_CYC, "R6 settle delay", rdy_rise - hv_rise, S_CYC);
    chk(busy_at_rdy == 1'b0, "R6 busy falls with ready", busy_at_rdy, 0);
    chk(r4_bad == 0, "R4 reset/hv complement", r4_bad, 0);
    chk(r5_bad == 0, "R5 pen frozen under hv", r5_bad, 0);
    baseline = rdy_rise - start_cyc;
    for (int i = 0; i < 30; i++) step();
    chk(ready && hv_en && pen == 4'h0, "R7 ready held", ready, 1);
  endtask

  task automatic t_start_busy_ignored();
    abort = 1; step(); abort = 0;
    clear_mon(); start_cyc = cyc;
    pulse_start();
    for (int i = 0; i < 4; i++) step();
    pulse_start();
    for (int i = 0; i < 20; i++) step();
    pulse_start();
    wait_ready("R9 ready after ignored starts");
    chk(rises_at_fall == PULSES, "R9 pulse count unchanged", rises_at_fall, PULSES);
    chk(rdy_rise - start_cyc == baseline, "R9 length unchanged", rdy_rise - start_cyc, baseline);
  endtask

  task automatic t_restart_from_ready();
    pulse_start();
    chk(!ready && busy && !hv_en, "R10 restart from ready", {ready, busy, hv_en}, 3'b010);
    wait_ready("R10 ready again");
  endtask

  task automatic t_abort_start_same();
    start = 1; abort = 1; step(); start = 0; abort = 0;
    expect_idle("R8 abort beats start");
    for (int i = 0; i < 10; i++) step();
    expect_idle("R8 stays idle");
  endtask

  task automatic t_abort_clocking();
    clear_mon();
    pulse_start();
    for (int i = 0; i < 5; i++) step();
    abort = 1; step(); abort = 0;
    expect_idle("R8 abort during burst");
  endtask

  task automatic t_abort_last_settle();
    pulse_start();
    for (int i = 0; i < 200 && !hv_en; i++) step();
    chk(hv_en, "R3 hv raised", hv_en, 1);
    for (int i = 0; i < S_CYC - 1; i++) step();
    chk(!ready, "R6 not ready before settle ends", ready, 0);
    abort = 1; step(); abort = 0;
    expect_idle("R8 abort beats completion");
    for (int i = 0; i < 5; i++) step();
    chk(!ready, "R8 ready never set", ready, 0);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_entry();
    t_restart_from_ready();
    t_abort_start_same();
    t_start_busy_ignored();
    t_abort_clocking();
    t_abort_last_settle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule